// File: doc/BRIEF.md
# Hashed Page Table Group Searcher

This block runs after a translation miss. It walks a hashed page table that sits in external memory and returns the real page number and the access rights for one effective address. The caller supplies the effective address, a 24-bit segment identifier, a protection key, a read/write flag and the table register. The table register holds the table base in bits [31:16] and a mask extension in bits [8:0].

The block first hashes the page index with the segment identifier to find a primary group of eight 8-byte entries. It fetches word0 of each entry. When word0 matches, it also fetches word1. If the primary group yields no usable entry, the block searches the secondary group, whose hash is the complement of the primary one. A protection fault in the primary group ends the search at once.

When an entry is found, the block sets the referenced bit. It sets the changed bit only on a permitted write. If the changed bit stays clear, write permission is withheld so that the first store faults. Word1 is written back only when one of these bits actually changes. A `start` pulse begins a search and a one-cycle `done` pulse ends it.

Top module: `pte_group_walker`

## Requirements
- R1: The first memory read of a search goes to the primary group address. That address is `{tbl[31:16],16'h0} | (H & M)`, where `H = ((seg ^ ea[27:12]) & 0x7FFFF) << 6` and `M = (tbl[8:0] << 16) | 0xFFC0`. Entry `i` sits at group+8·i, with word0 at +0 and word1 at +4.
- R2: An entry matches only when three conditions hold. Word0 bit 31 is 1. Word0 bit 6 equals the pass (0 primary, 1 secondary). Word0 with bits 31 and 6 cleared equals `(seg << 7) | ea[27:22]`. Entries that are not valid, or that carry the wrong pass bit, are skipped.
- R3: The secondary group uses hash `~H & 0x01FFFFC0` and is searched only when the primary pass ends in a miss. A protection fault in the primary pass ends the search without any secondary read.
- R4: With key 0, reads are always allowed. Writes are allowed unless word1 bits [1:0] equal 3.
- R5: With key 1, the value of word1 bits [1:0] sets the rights. 0 grants no access. 1 and 3 grant read only. 2 grants read and write.
- R6: Matching entries in one group whose word1 values differ under mask 0xFFFFF07B make that pass a miss, and nothing is written back. The result encoding is 0 hit, 1 miss, 2 protection fault. A miss reports both permissions as 0.
- R7: Once any entry is located, whether the result is a hit or a fault, its word1 gets the referenced bit (0x100). Word1 is written back, to the first permitted matching entry (or the first match when none is permitted), only when its value changes.
- R8: The changed bit (0x80) is set only on a permitted write. While the changed bit remains clear, the reported write permission is 0.
- R9: On a hit or a fault, the reported real page number is word1 & 0xFFFFF000.
- R10: `done` is a one-cycle pulse. The result outputs hold their values after `done` until the next `start`. A memory request keeps its address and direction until `mem_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a search |
| ea | input | 32 | Effective address |
| seg_id | input | 24 | Segment identifier |
| key | input | 1 | Protection key |
| is_write | input | 1 | 1 for a store access |
| tbl_reg | input | 32 | Table base [31:16] and mask extension [8:0] |
| done | output | 1 | Search-complete pulse |
| result | output | 2 | 0 hit, 1 miss, 2 protection fault |
| rpn | output | 32 | Real page number, page aligned |
| perm_rd | output | 1 | Read permitted |
| perm_wr | output | 1 | Write permitted |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request accepted; read data valid this cycle |
| mem_rdata | input | 32 | Read data |

## Verification
A vector table places one entry in turn in every protection-bit value, under both keys, for reads and for writes. The entries start with the referenced and changed flags in different states, and some sit in the secondary group. This separates wrong rights decoding from wrong flag update, and a wrong write-back from a missing one. Directed cases then separate the cases that end a pass:
- an empty table, which must cost exactly sixteen reads;
- a primary fault, which must stop after nine reads;
- entries that are not valid or carry the wrong pass bit;
- duplicates that disagree under the mask, against duplicates that differ only in the flag bits;
- a consistent duplicate, which checks which slot receives the write-back.

// File: rtl/pte_walk_pkg.sv
package pte_walk_pkg;

    localparam int SEG_W           = 24;
    localparam int SLOTS_PER_GROUP = 8;

    localparam logic [31:0] W1_CMP_MASK = 32'hFFFF_F07B;
    localparam logic [31:0] REF_BIT     = 32'h0000_0100;
    localparam logic [31:0] CHG_BIT     = 32'h0000_0080;
    localparam logic [31:0] RPN_MASK    = 32'hFFFF_F000;
    localparam logic [31:0] W0_CTL_BITS = 32'h8000_0040;

    typedef enum logic [1:0] {
        RES_HIT   = 2'd0,
        RES_MISS  = 2'd1,
        RES_FAULT = 2'd2
    } walk_res_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD0  = 2'd1,
        ST_RD1  = 2'd2,
        ST_WB   = 2'd3
    } walk_st_e;

endpackage

// File: rtl/pte_hash_calc.sv
module pte_hash_calc
    import pte_walk_pkg::*;
(
    input  logic [15:0]      pidx,
    input  logic [SEG_W-1:0] seg_id,
    input  logic [15:0]      tbase,
    input  logic [8:0]       tmsk,
    input  logic             sec,
    output logic [31:0]      grp_addr,
    output logic [31:0]      cmp_word
);
    logic [31:0] h_pri;
    logic [31:0] h_sec;
    logic [31:0] msk;

    always_comb begin
        h_pri    = ((32'(seg_id) ^ 32'(pidx)) & 32'h0007_FFFF) << 6;
        h_sec    = ~h_pri & 32'h01FF_FFC0;
        msk      = {7'b0, tmsk, 16'h0} | 32'h0000_FFC0;
        grp_addr = {tbase, 16'h0} | ((sec ? h_sec : h_pri) & msk);
        cmp_word = {1'b0, seg_id, 7'b0} | {26'b0, pidx[15:10]};
    end
endmodule

// File: rtl/pte_access_decode.sv
module pte_access_decode (
    input  logic       key,
    input  logic [1:0] pp,
    output logic       can_rd,
    output logic       can_wr
);
    always_comb begin
        if (!key) begin
            can_rd = 1'b1;
            can_wr = (pp != 2'd3);
        end else begin
            can_rd = (pp != 2'd0);
            can_wr = (pp == 2'd2);
        end
    end
endmodule

// File: rtl/pte_group_walker.sv
module pte_group_walker
    import pte_walk_pkg::*;
#(
    parameter int N_SLOTS = SLOTS_PER_GROUP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [31:0]      ea,
    input  logic [SEG_W-1:0] seg_id,
    input  logic             key,
    input  logic             is_write,
    input  logic [31:0]      tbl_reg,
    output logic             done,
    output logic [1:0]       result,
    output logic [31:0]      rpn,
    output logic             perm_rd,
    output logic             perm_wr,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ready,
    input  logic [31:0]      mem_rdata
);
    localparam int IDX_W = $clog2(N_SLOTS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SLOTS - 1);

    typedef struct packed {
        walk_st_e         st;
        logic             pass;
        logic [IDX_W-1:0] idx;
        logic             found;
        logic             hitq;
        logic [31:0]      keep;
        logic [IDX_W-1:0] kidx;
        logic [15:0]      pidx;
        logic [SEG_W-1:0] seg;
        logic             key;
        logic             wr;
        logic [15:0]      tbase;
        logic [8:0]       tmsk;
        logic             done;
        walk_res_e        res;
        logic [31:0]      rpn;
        logic             ord;
        logic             owr;
    } walk_t;

    walk_t q, d;

    logic [31:0] grp_addr;
    logic [31:0] cmp_word;
    logic        can_rd, can_wr;
    logic        end_pass, incons, w0_hit, allowed;
    logic [31:0] upd;
    logic        unused_ok;

    assign unused_ok = ^{ea[31:28], ea[11:0], tbl_reg[15:9]};

    pte_hash_calc u_hash (
        .pidx     (q.pidx),
        .seg_id   (q.seg),
        .tbase    (q.tbase),
        .tmsk     (q.tmsk),
        .sec      (q.pass),
        .grp_addr (grp_addr),
        .cmp_word (cmp_word)
    );

    pte_access_decode u_acc (
        .key    (q.key),
        .pp     (mem_rdata[1:0]),
        .can_rd (can_rd),
        .can_wr (can_wr)
    );

    // Memory side
    always_comb begin
        mem_req   = (q.st != ST_IDLE);
        mem_we    = (q.st == ST_WB);
        mem_wdata = q.keep;
        case (q.st)
            ST_RD1:  mem_addr = grp_addr + 32'({q.idx, 3'b100});
            ST_WB:   mem_addr = grp_addr + 32'({q.kidx, 3'b100});
            default: mem_addr = grp_addr + 32'({q.idx, 3'b000});
        endcase
    end

    // Next-state computation
    always_comb begin
        d        = q;
        d.done   = 1'b0;
        end_pass = 1'b0;
        incons   = 1'b0;
        upd      = '0;
        w0_hit   = mem_rdata[31] && (mem_rdata[6] == q.pass) &&
                   ((mem_rdata & ~W0_CTL_BITS) == cmp_word);
        allowed  = q.wr ? can_wr : can_rd;

        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.pidx  = ea[27:12];
                    d.seg   = seg_id;
                    d.key   = key;
                    d.wr    = is_write;
                    d.tbase = tbl_reg[31:16];
                    d.tmsk  = tbl_reg[8:0];
                    d.pass  = 1'b0;
                    d.idx   = '0;
                    d.found = 1'b0;
                    d.hitq  = 1'b0;
                    d.st    = ST_RD0;
                end
            end
            ST_RD0: begin
                if (mem_ready) begin
                    if (w0_hit)                d.st = ST_RD1;
                    else if (q.idx == LAST_IDX) end_pass = 1'b1;
                    else                        d.idx = q.idx + 1'b1;
                end
            end
            ST_RD1: begin
                if (mem_ready) begin
                    if (q.found && (((q.keep ^ mem_rdata) & W1_CMP_MASK) != '0)) begin
                        incons   = 1'b1;
                        end_pass = 1'b1;
                    end else begin
                        if (!q.found) begin
                            d.found = 1'b1;
                            d.keep  = mem_rdata;
                            d.kidx  = q.idx;
                        end
                        if (!q.hitq) begin
                            d.ord = can_rd;
                            d.owr = can_wr;
                            if (allowed) begin
                                d.hitq = 1'b1;
                                d.keep = mem_rdata;
                                d.kidx = q.idx;
                            end
                        end
                        if (q.idx == LAST_IDX) begin
                            end_pass = 1'b1;
                        end else begin
                            d.idx = q.idx + 1'b1;
                            d.st  = ST_RD0;
                        end
                    end
                end
            end
            ST_WB: begin
                if (mem_ready) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (end_pass) begin
            if (incons || !d.found) begin
                if (!q.pass) begin
                    d.pass  = 1'b1;
                    d.idx   = '0;
                    d.found = 1'b0;
                    d.hitq  = 1'b0;
                    d.st    = ST_RD0;
                end else begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    d.res  = RES_MISS;
                    d.rpn  = '0;
                    d.ord  = 1'b0;
                    d.owr  = 1'b0;
                end
            end else begin
                upd = d.keep | REF_BIT;
                if ((d.keep & CHG_BIT) == '0) begin
                    if (q.wr && d.hitq) upd = upd | CHG_BIT;
                    else                d.owr = 1'b0;
                end
                d.rpn = d.keep & RPN_MASK;
                d.res = d.hitq ? RES_HIT : RES_FAULT;
                if (upd != d.keep) begin
                    d.keep = upd;
                    d.st   = ST_WB;
                end else begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done    = q.done;
    assign result  = q.res;
    assign rpn     = q.rpn;
    assign perm_rd = q.ord;
    assign perm_wr = q.owr;

endmodule

// File: rtl/pte_walk_checker.sv
module pte_walk_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        done,
    input logic [1:0]  result,
    input logic        perm_rd,
    input logic        perm_wr,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ready
);
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_quiet_at_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    assert_wb_word1_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr[2:0] == 3'b100));

    assert_wb_ref_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[8]);

    assert_hit_reads_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 2'd0) |-> perm_rd);

    assert_miss_noperm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 2'd1) |-> (!perm_rd && !perm_wr));
endmodule

bind pte_group_walker pte_walk_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .result    (result),
    .perm_rd   (perm_rd),
    .perm_wr   (perm_wr),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready)
);

// File: tb/tb_pte_group_walker.sv
`timescale 1ns/1ps
module tb_pte_group_walker;

    typedef struct packed {
        logic [31:0] ea;
        logic [23:0] seg;
        logic        key;
        logic        wr;
        logic        sec;
        logic [2:0]  slot;
        logic [31:0] w1;
        logic [1:0]  eres;
        logic        erd;
        logic        ewr;
        logic        ewb;
        logic [31:0] ewd;
    } vec_t;

    localparam int NV = 9;
    localparam logic [31:0] TBL = 32'h0040_0003;
    localparam vec_t VEC [NV] = '{
        '{32'h1357_9000, 24'h00A5A5, 1'b0, 1'b0, 1'b0, 3'd3, 32'h1234_5002, 2'd0, 1'b1, 1'b0, 1'b1, 32'h1234_5102},
        '{32'h2468_A000, 24'h012345, 1'b0, 1'b1, 1'b0, 3'd0, 32'hABCD_E180, 2'd0, 1'b1, 1'b1, 1'b0, 32'h0},
        '{32'hFEDC_B000, 24'hFFFFFF, 1'b0, 1'b1, 1'b0, 3'd7, 32'h0000_7183, 2'd2, 1'b1, 1'b0, 1'b0, 32'h0},
        '{32'h0000_1000, 24'h000001, 1'b1, 1'b0, 1'b0, 3'd1, 32'h0001_1100, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0},
        '{32'h8000_F000, 24'h800000, 1'b1, 1'b0, 1'b0, 3'd2, 32'h0002_2001, 2'd0, 1'b1, 1'b0, 1'b1, 32'h0002_2101},
        '{32'h7FFF_F000, 24'h0F0F0F, 1'b1, 1'b1, 1'b0, 3'd5, 32'h0003_3002, 2'd0, 1'b1, 1'b1, 1'b1, 32'h0003_3182},
        '{32'h4444_4000, 24'h333333, 1'b1, 1'b1, 1'b0, 3'd6, 32'h0004_4183, 2'd2, 1'b1, 1'b0, 1'b0, 32'h0},
        '{32'h5555_5000, 24'h0ABCDE, 1'b0, 1'b1, 1'b1, 3'd7, 32'h0005_5000, 2'd0, 1'b1, 1'b1, 1'b1, 32'h0005_5180},
        '{32'h9ABC_D000, 24'h123456, 1'b0, 1'b0, 1'b1, 3'd4, 32'h0006_6181, 2'd0, 1'b1, 1'b1, 1'b0, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] ea = '0;
    logic [23:0] seg_id = '0;
    logic        key = 1'b0;
    logic        is_write = 1'b0;
    logic [31:0] tbl_reg = '0;
    logic        done;
    logic [1:0]  result;
    logic [31:0] rpn;
    logic        perm_rd, perm_wr;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready;
    logic [31:0] mem_rdata;

    int checks = 0;
    int fails  = 0;

    logic [31:0] mem [logic [31:0]];
    int          n_rd, n_wr;
    logic [31:0] last_wa, last_wd, first_ra;
    logic        first_seen;

    logic [1:0]  g_res;
    logic [31:0] g_rpn;
    logic        g_rd, g_wr;

    always #4 clk = ~clk;

    pte_group_walker dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ea(ea), .seg_id(seg_id),
        .key(key), .is_write(is_write), .tbl_reg(tbl_reg), .done(done),
        .result(result), .rpn(rpn), .perm_rd(perm_rd), .perm_wr(perm_wr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    // Memory model: ready one cycle after a request is seen
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ready <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ready <= mem_req && !mem_ready;
            if (mem_req && !mem_ready) begin
                if (mem_we) begin
                    mem[mem_addr] = mem_wdata;
                    n_wr++;
                    last_wa = mem_addr;
                    last_wd = mem_wdata;
                end else begin
                    mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                    n_rd++;
                    if (!first_seen) begin
                        first_seen = 1'b1;
                        first_ra   = mem_addr;
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R10 watchdog expired act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    function automatic logic [31:0] grp_of(input logic [31:0] a, input logic [23:0] s,
                                           input logic [31:0] t, input logic sc);
        logic [31:0] h, m;
        h = ((32'(s) ^ 32'(a[27:12])) & 32'h0007_FFFF) << 6;
        if (sc) h = ~h & 32'h01FF_FFC0;
        m = (32'(t[8:0]) << 16) | 32'h0000_FFC0;
        return (t & 32'hFFFF_0000) | (h & m);
    endfunction

    function automatic logic [31:0] w0_of(input logic [31:0] a, input logic [23:0] s, input logic sc);
        return 32'h8000_0000 | (32'(s) << 7) | 32'(a[27:22]) | (sc ? 32'h40 : 32'h0);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic plant(input logic [31:0] g, input int slot, input logic [31:0] w0, input logic [31:0] w1);
        mem[g + 32'(slot * 8)]     = w0;
        mem[g + 32'(slot * 8) + 4] = w1;
    endtask

    task automatic run(input logic [31:0] a, input logic [23:0] s, input logic k, input logic w);
        int waitc;
        @(negedge clk);
        ea = a; seg_id = s; key = k; is_write = w; tbl_reg = TBL;
        n_rd = 0; n_wr = 0; first_seen = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        waitc = 0;
        while (!done && waitc < 2000) begin
            @(negedge clk);
            waitc++;
        end
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL R10 no done act=0 exp=1");
        end
        g_res = result; g_rpn = rpn; g_rd = perm_rd; g_wr = perm_wr;
        @(negedge clk);
        chk("R10 done pulse width", 32'(done), 32'd0);
        chk("R10 result held", 32'(result), 32'(g_res));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset done", 32'(done), 32'd0);
        chk("R10 reset mem_req", 32'(mem_req), 32'd0);

        // Vector table: R1 R4 R5 R7 R8 R9, secondary entries R3
        for (int i = 0; i < NV; i++) begin
            logic [31:0] g;
            mem.delete();
            g = grp_of(VEC[i].ea, VEC[i].seg, TBL, VEC[i].sec);
            plant(g, int'(VEC[i].slot), w0_of(VEC[i].ea, VEC[i].seg, VEC[i].sec), VEC[i].w1);
            run(VEC[i].ea, VEC[i].seg, VEC[i].key, VEC[i].wr);
            chk($sformatf("R1 vec%0d primary address", i), first_ra, grp_of(VEC[i].ea, VEC[i].seg, TBL, 1'b0));
            chk($sformatf("R4 R5 vec%0d result", i), 32'(g_res), 32'(VEC[i].eres));
            chk($sformatf("R4 R5 vec%0d read perm", i), 32'(g_rd), 32'(VEC[i].erd));
            chk($sformatf("R8 vec%0d write perm", i), 32'(g_wr), 32'(VEC[i].ewr));
            chk($sformatf("R9 vec%0d rpn", i), g_rpn, VEC[i].w1 & 32'hFFFF_F000);
            chk($sformatf("R7 vec%0d writeback count", i), 32'(n_wr), 32'(VEC[i].ewb));
            if (VEC[i].ewb) begin
                chk($sformatf("R8 vec%0d writeback data", i), last_wd, VEC[i].ewd);
                chk($sformatf("R3 vec%0d writeback address", i), last_wa, g + 32'(VEC[i].slot) * 8 + 4);
            end
        end

        // R3: empty table searches both groups
        mem.delete();
        run(32'h0123_4000, 24'h00BEEF, 1'b0, 1'b0);
        chk("R3 empty result", 32'(g_res), 32'd1);
        chk("R3 empty reads both passes", 32'(n_rd), 32'd16);
        chk("R6 empty rpn", g_rpn, 32'h0);

        // R3: primary fault must not start the secondary pass
        mem.delete();
        plant(grp_of(32'h0246_8000, 24'h000777, TBL, 1'b0), 2,
              w0_of(32'h0246_8000, 24'h000777, 1'b0), 32'h0009_9181);
        plant(grp_of(32'h0246_8000, 24'h000777, TBL, 1'b1), 0,
              w0_of(32'h0246_8000, 24'h000777, 1'b1), 32'h000A_A182);
        run(32'h0246_8000, 24'h000777, 1'b1, 1'b1);
        chk("R3 primary fault result", 32'(g_res), 32'd2);
        chk("R3 primary fault read count", 32'(n_rd), 32'd9);

        // R2: invalid and wrong-pass entries are skipped
        mem.delete();
        plant(grp_of(32'h0333_3000, 24'h0000AB, TBL, 1'b0), 0,
              w0_of(32'h0333_3000, 24'h0000AB, 1'b0) & 32'h7FFF_FFFF, 32'h000B_B002);
        plant(grp_of(32'h0333_3000, 24'h0000AB, TBL, 1'b0), 1,
              w0_of(32'h0333_3000, 24'h0000AB, 1'b1), 32'h000B_B002);
        plant(grp_of(32'h0333_3000, 24'h0000AB, TBL, 1'b1), 3,
              w0_of(32'h0333_3000, 24'h0000AB, 1'b0), 32'h000B_B002);
        run(32'h0333_3000, 24'h0000AB, 1'b0, 1'b0);
        chk("R2 skipped entries result", 32'(g_res), 32'd1);
        chk("R2 skipped entries no write", 32'(n_wr), 32'd0);

        // R6: disagreeing duplicates give a miss
        mem.delete();
        plant(grp_of(32'h0444_4000, 24'h00CAFE, TBL, 1'b0), 1,
              w0_of(32'h0444_4000, 24'h00CAFE, 1'b0), 32'h1111_1002);
        plant(grp_of(32'h0444_4000, 24'h00CAFE, TBL, 1'b0), 4,
              w0_of(32'h0444_4000, 24'h00CAFE, 1'b0), 32'h2222_2002);
        run(32'h0444_4000, 24'h00CAFE, 1'b0, 1'b0);
        chk("R6 inconsistent result", 32'(g_res), 32'd1);
        chk("R6 inconsistent no write", 32'(n_wr), 32'd0);
        chk("R6 inconsistent read perm", 32'(g_rd), 32'd0);

        // R6: duplicates differing only in flag bits agree
        mem.delete();
        plant(grp_of(32'h0555_5000, 24'h00F00D, TBL, 1'b0), 1,
              w0_of(32'h0555_5000, 24'h00F00D, 1'b0), 32'h1111_1102);
        plant(grp_of(32'h0555_5000, 24'h00F00D, TBL, 1'b0), 4,
              w0_of(32'h0555_5000, 24'h00F00D, 1'b0), 32'h1111_1082);
        run(32'h0555_5000, 24'h00F00D, 1'b0, 1'b0);
        chk("R6 flag-only duplicates result", 32'(g_res), 32'd0);
        chk("R8 flag-only duplicates write perm", 32'(g_wr), 32'd0);
        chk("R7 flag-only duplicates no write", 32'(n_wr), 32'd0);

        // R7: consistent duplicate, write-back goes to the first slot
        mem.delete();
        plant(grp_of(32'h0666_6000, 24'h00D00D, TBL, 1'b0), 2,
              w0_of(32'h0666_6000, 24'h00D00D, 1'b0), 32'h0008_8002);
        plant(grp_of(32'h0666_6000, 24'h00D00D, TBL, 1'b0), 5,
              w0_of(32'h0666_6000, 24'h00D00D, 1'b0), 32'h0008_8002);
        run(32'h0666_6000, 24'h00D00D, 1'b0, 1'b0);
        chk("R7 duplicate result", 32'(g_res), 32'd0);
        chk("R7 duplicate write address", last_wa,
            grp_of(32'h0666_6000, 24'h00D00D, TBL, 1'b0) + 32'd20);
        chk("R7 duplicate write data", last_wd, 32'h0008_8102);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule